// File: doc/BRIEF.md
# Power-Save Look-Ahead Qualifier

This block decides whether a three-engine LED sequencer may drop into its low-power state. Each engine reports its operating mode, a class code for the command it is executing, the ticks still left on that command, its prescale bit, its present PWM value, the wait length of the command that follows, and the reset-to-zero bit of an end command. The block reduces each engine to a single "may sleep" verdict. It raises a power-save request only when the global enable is set and all three verdicts agree.

Entry is evaluated on an instruction-cycle strobe. Exit is immediate: the request drops combinationally in the very cycle any engine or the enable withdraws, and a one-cycle wake request marks that moment so the analogue and clock logic can restart without a register stage of delay. All times are counted in ticks of the 32.768 kHz sequencer clock. 50 ms is 1639 ticks and 80 ms is 2622 ticks. The block has no data stream, so every pin is a plain control or status level.

Top module: `ps_lookahead`

## Requirements
- R1: After reset, ps_req and wake_req are both 0, and every engine's stored verdict is "blocks".
- R2: The block qualifies only when ps_en is 1 and all three engine verdicts are "may sleep". A single blocking engine or ps_en=0 prevents entry.
- R3: The mode code decides the verdict as follows:
  - 0 (off) always qualifies.
  - 1 (program load) always blocks.
  - 3 (direct drive) qualifies only when that engine's PWM is 0.
  - 2 (run) follows the command rules R4–R8.
- R4: Command class 1 (wait) and class 2 (ramp) qualify only when the PWM is 0 and the remaining ticks exceed 1639 (prescale 0) or 2622 (prescale 1). Exactly 1639 or 2622 ticks does not qualify.
- R5: Command class 3 (wait for trigger) qualifies when the PWM is 0.
- R6: Command class 4 (end) qualifies when the PWM is 0 or the end reset bit is 1.
- R7: Command class 5 (set brightness) qualifies only when the PWM value being set is 0 and the next command's wait is at least 1639 ticks.
- R8: Class codes 0, 6 and 7 neither grant nor block:
  - A run-mode engine keeps the verdict stored at its last strobe that carried a class 1–5 command.
  - That stored verdict is updated only on a strobe in run mode.
- R9: ps_req can rise only in the cycle after a clock edge at which cyc_stb was 1 and the block qualified.
- R10: When qualification is lost, ps_req falls in the same cycle and wake_req is 1 for exactly that one cycle. ps_req and wake_req are never both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ps_en | input | 1 | Global power-save enable |
| cyc_stb | input | 1 | Instruction-cycle strobe, entry evaluated here |
| eng_mode | input | NUM_ENG*2 | Per-engine mode code, engine e at [2e+1:2e] |
| eng_cmd | input | NUM_ENG*3 | Per-engine command class code |
| eng_remain | input | NUM_ENG*TICK_W | Ticks left on the current command |
| eng_prescale | input | NUM_ENG | Prescale bit of the current command |
| eng_pwm | input | NUM_ENG*PWM_W | Present or being-set PWM value |
| eng_next_wait | input | NUM_ENG*TICK_W | Wait ticks produced by the next command |
| eng_end_rst | input | NUM_ENG | Reset-to-zero bit of an end command |
| ps_req | output | 1 | Power-save request |
| wake_req | output | 1 | One-cycle wake pulse on loss of qualification |

## Verification
Qualification is combinational, so ps_req falling and wake_req rising are due in the same cycle as the input change. A new entry is due one clock edge after a qualifying strobe. A stored verdict for a neutral command is due after the strobe edge that captured it. The bench drives inputs on the falling edge and compares one nanosecond later. It then updates its own model state at the following rising edge, so every comparison sees exactly the registers that have switched by then.

// File: rtl/ps_la_pkg.sv
package ps_la_pkg;
  typedef enum logic [1:0] {
    MD_OFF    = 2'd0,
    MD_LOAD   = 2'd1,
    MD_RUN    = 2'd2,
    MD_DIRECT = 2'd3
  } mode_e;

  localparam logic [2:0] CK_OTHER = 3'd0;
  localparam logic [2:0] CK_WAIT  = 3'd1;
  localparam logic [2:0] CK_RAMP  = 3'd2;
  localparam logic [2:0] CK_TRIG  = 3'd3;
  localparam logic [2:0] CK_END   = 3'd4;
  localparam logic [2:0] CK_SET   = 3'd5;
endpackage

// File: rtl/ps_la_thresh.sv
// Remaining-time comparator: threshold chosen by the prescale bit.
module ps_la_thresh #(
  parameter int TICK_W  = 23,
  parameter int TH_FAST = 1639,
  parameter int TH_SLOW = 2622
) (
  input  logic              prescale,
  input  logic [TICK_W-1:0] remain,
  output logic              above
);
  localparam logic [TICK_W-1:0] LIM_F = TICK_W'(TH_FAST);
  localparam logic [TICK_W-1:0] LIM_S = TICK_W'(TH_SLOW);

  logic [TICK_W-1:0] lim;
  assign lim   = prescale ? LIM_S : LIM_F;
  assign above = remain > lim;
endmodule

// File: rtl/ps_la_engine.sv
// Per-engine verdict: mode rules, command rules and the stored verdict
// used while a neutral command executes.
module ps_la_engine
  import ps_la_pkg::*;
#(
  parameter int TICK_W  = 23,
  parameter int PWM_W   = 8,
  parameter int TH_FAST = 1639,
  parameter int TH_SLOW = 2622,
  parameter int SET_MIN = 1639
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              stb,
  input  logic [1:0]        mode,
  input  logic [2:0]        cmd,
  input  logic [TICK_W-1:0] remain,
  input  logic              prescale,
  input  logic [PWM_W-1:0]  pwm,
  input  logic [TICK_W-1:0] next_wait,
  input  logic              end_rst,
  output logic              qual
);
  localparam logic [TICK_W-1:0] SET_LIM = TICK_W'(SET_MIN);

  logic pwm_idle, above, set_ok, run_q, decisive, held_q;

  assign pwm_idle = (pwm == '0);
  assign set_ok   = (next_wait >= SET_LIM);

  ps_la_thresh #(.TICK_W(TICK_W), .TH_FAST(TH_FAST), .TH_SLOW(TH_SLOW)) thr_i (
    .prescale(prescale), .remain(remain), .above(above)
  );

  always_comb begin
    decisive = 1'b1;
    case (cmd)
      CK_WAIT, CK_RAMP: run_q = pwm_idle & above;
      CK_TRIG:          run_q = pwm_idle;
      CK_END:           run_q = pwm_idle | end_rst;
      CK_SET:           run_q = pwm_idle & set_ok;
      default: begin
        run_q    = held_q;
        decisive = 1'b0;
      end
    endcase
  end

  always_comb begin
    case (mode_e'(mode))
      MD_OFF:    qual = 1'b1;
      MD_LOAD:   qual = 1'b0;
      MD_DIRECT: qual = pwm_idle;
      default:   qual = run_q;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n)
      held_q <= 1'b0;
    else if (stb && mode == MD_RUN && decisive)
      held_q <= run_q;
  end

  // R3: a loading engine never grants
  p_load_blocks_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MD_LOAD) |-> !qual);
  // R8: stored verdict moves only on a strobe
  p_held_stable_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !stb |=> $stable(held_q));
  // R4: wait/ramp with active PWM blocks in run mode
  p_busy_blocks_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MD_RUN && (cmd == CK_WAIT || cmd == CK_RAMP) && pwm != '0) |-> !qual);
endmodule

// File: rtl/ps_lookahead.sv
// Top: unanimity across engines, strobe-timed entry, immediate exit.
module ps_lookahead
  import ps_la_pkg::*;
#(
  parameter int NUM_ENG = 3,
  parameter int TICK_W  = 23,
  parameter int PWM_W   = 8,
  parameter int TH_FAST = 1639,
  parameter int TH_SLOW = 2622,
  parameter int SET_MIN = 1639
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      ps_en,
  input  logic                      cyc_stb,
  input  logic [NUM_ENG*2-1:0]      eng_mode,
  input  logic [NUM_ENG*3-1:0]      eng_cmd,
  input  logic [NUM_ENG*TICK_W-1:0] eng_remain,
  input  logic [NUM_ENG-1:0]        eng_prescale,
  input  logic [NUM_ENG*PWM_W-1:0]  eng_pwm,
  input  logic [NUM_ENG*TICK_W-1:0] eng_next_wait,
  input  logic [NUM_ENG-1:0]        eng_end_rst,
  output logic                      ps_req,
  output logic                      wake_req
);
  logic [NUM_ENG-1:0] qual_v;
  logic ok, ps_q;

  for (genvar e = 0; e < NUM_ENG; e++) begin : g_eng
    ps_la_engine #(
      .TICK_W(TICK_W), .PWM_W(PWM_W), .TH_FAST(TH_FAST),
      .TH_SLOW(TH_SLOW), .SET_MIN(SET_MIN)
    ) eng_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .stb      (cyc_stb),
      .mode     (eng_mode[e*2 +: 2]),
      .cmd      (eng_cmd[e*3 +: 3]),
      .remain   (eng_remain[e*TICK_W +: TICK_W]),
      .prescale (eng_prescale[e]),
      .pwm      (eng_pwm[e*PWM_W +: PWM_W]),
      .next_wait(eng_next_wait[e*TICK_W +: TICK_W]),
      .end_rst  (eng_end_rst[e]),
      .qual     (qual_v[e])
    );
  end

  assign ok = ps_en & (&qual_v);

  always_ff @(posedge clk) begin
    if (!rst_n)     ps_q <= 1'b0;
    else if (!ok)   ps_q <= 1'b0;
    else if (cyc_stb) ps_q <= 1'b1;
  end

  assign ps_req   = ps_q & ok;
  assign wake_req = ps_q & ~ok;

  // R2: request never stands without the enable
  p_need_en_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ps_req |-> ps_en);
  // R9: entry follows a strobe
  p_entry_strobe_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ps_req) |-> $past(cyc_stb));
  // R10: wake is a single-cycle pulse followed by no request
  p_wake_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    wake_req |=> (!wake_req && !ps_req));
  // R10: exclusive outputs
  p_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(ps_req && wake_req));
endmodule

// File: tb/ps_lookahead_tb.sv
module ps_lookahead_tb_top;
  localparam int NE = 3;
  localparam int TW = 23;
  localparam int PW = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ps_en = 1'b0;
  logic cyc_stb = 1'b0;
  logic [1:0]    md [NE];
  logic [2:0]    ck [NE];
  logic [TW-1:0] rem [NE];
  logic          psc [NE];
  logic [PW-1:0] pwm [NE];
  logic [TW-1:0] nxt [NE];
  logic          ers [NE];
  logic ps_req, wake_req;

  logic m_held [NE];
  logic m_psq;
  int n_cmp = 0;
  int n_bad = 0;

  always #2 clk = ~clk;

  ps_lookahead dut_i (
    .clk(clk), .rst_n(rst_n), .ps_en(ps_en), .cyc_stb(cyc_stb),
    .eng_mode({md[2], md[1], md[0]}),
    .eng_cmd({ck[2], ck[1], ck[0]}),
    .eng_remain({rem[2], rem[1], rem[0]}),
    .eng_prescale({psc[2], psc[1], psc[0]}),
    .eng_pwm({pwm[2], pwm[1], pwm[0]}),
    .eng_next_wait({nxt[2], nxt[1], nxt[0]}),
    .eng_end_rst({ers[2], ers[1], ers[0]}),
    .ps_req(ps_req), .wake_req(wake_req)
  );

  function automatic bit neutral(input logic [2:0] c);
    return !(c >= 3'd1 && c <= 3'd5);
  endfunction

  function automatic bit run_verdict(input int e);
    bit idle = (pwm[e] == 0);
    int lim = psc[e] ? 2622 : 1639;
    case (ck[e])
      3'd1, 3'd2: return idle && (int'(rem[e]) > lim);
      3'd3:       return idle;
      3'd4:       return idle || ers[e];
      3'd5:       return idle && (int'(nxt[e]) >= 1639);
      default:    return m_held[e];
    endcase
  endfunction

  function automatic bit eng_verdict(input int e);
    case (md[e])
      2'd0:    return 1'b1;
      2'd1:    return 1'b0;
      2'd3:    return pwm[e] == 0;
      default: return run_verdict(e);
    endcase
  endfunction

  function automatic bit model_ok();
    bit all = 1'b1;
    for (int e = 0; e < NE; e++) all &= eng_verdict(e);
    return ps_en && all;
  endfunction

  task automatic cmp(input string tag, input logic got, input logic exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %0b expected %0b at %0t", tag, got, exp, $time);
    end
  endtask

  // Called just after a falling edge with inputs settled; checks, then
  // advances the model across the next rising edge.
  task automatic step(input string tag);
    bit ok;
    bit nheld [NE];
    #1;
    ok = model_ok();
    cmp({tag, " ps_req"}, ps_req, m_psq && ok);
    cmp({tag, " wake_req"}, wake_req, m_psq && !ok);
    for (int e = 0; e < NE; e++) begin
      nheld[e] = m_held[e];
      if (cyc_stb && md[e] == 2'd2 && !neutral(ck[e])) nheld[e] = run_verdict(e);
    end
    @(posedge clk);
    for (int e = 0; e < NE; e++) m_held[e] = nheld[e];
    m_psq = ok ? (m_psq || cyc_stb) : 1'b0;
    @(negedge clk);
  endtask

  task automatic idle_all();
    for (int e = 0; e < NE; e++) begin
      md[e] = 2'd0; ck[e] = 3'd0; rem[e] = '0; psc[e] = 1'b0;
      pwm[e] = '0; nxt[e] = '0; ers[e] = 1'b0;
    end
  endtask

  // One engine configured, others off, strobe then hold; check entry.
  task automatic probe(input string tag, input bit exp);
    ps_en = 1'b1; cyc_stb = 1'b1;
    step(tag);
    cyc_stb = 1'b0;
    step(tag);
    #1; cmp({tag, " directed"}, ps_req, exp);
    ps_en = 1'b0;
    step(tag);
    idle_all();
  endtask

  initial begin
    #400000;
    n_bad++;
    $display("FAIL watchdog: got hung expected done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    idle_all();
    for (int e = 0; e < NE; e++) m_held[e] = 1'b0;
    m_psq = 1'b0;
    repeat (3) @(negedge clk);
    #1; cmp("R1 reset ps_req", ps_req, 1'b0);
    cmp("R1 reset wake_req", wake_req, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);

    // R1/R8: run mode with neutral command uses reset verdict (blocks)
    md[0] = 2'd2; ck[0] = 3'd0; probe("R1 R8 neutral after reset", 1'b0);
    // R2: all off but enable low
    ps_en = 1'b0; cyc_stb = 1'b1; step("R2 en low"); cyc_stb = 1'b0; step("R2 en low");
    #1; cmp("R2 en low directed", ps_req, 1'b0);
    // R3 modes
    md[1] = 2'd1; probe("R3 load blocks", 1'b0);
    md[2] = 2'd3; pwm[2] = 8'd5; probe("R3 direct busy", 1'b0);
    md[2] = 2'd3; probe("R3 direct idle", 1'b1);
    // R4 thresholds
    md[0] = 2'd2; ck[0] = 3'd1; rem[0] = 23'd1639; probe("R4 wait 1639", 1'b0);
    md[0] = 2'd2; ck[0] = 3'd1; rem[0] = 23'd1640; probe("R4 wait 1640", 1'b1);
    md[0] = 2'd2; ck[0] = 3'd2; rem[0] = 23'd2622; psc[0] = 1'b1; probe("R4 ramp 2622 slow", 1'b0);
    md[0] = 2'd2; ck[0] = 3'd2; rem[0] = 23'd2623; psc[0] = 1'b1; probe("R4 ramp 2623 slow", 1'b1);
    md[0] = 2'd2; ck[0] = 3'd2; rem[0] = 23'd9000; pwm[0] = 8'd1; probe("R4 ramp busy", 1'b0);
    // R5
    md[1] = 2'd2; ck[1] = 3'd3; probe("R5 trig idle", 1'b1);
    md[1] = 2'd2; ck[1] = 3'd3; pwm[1] = 8'hff; probe("R5 trig busy", 1'b0);
    // R6
    md[2] = 2'd2; ck[2] = 3'd4; pwm[2] = 8'd9; ers[2] = 1'b1; probe("R6 end reset", 1'b1);
    md[2] = 2'd2; ck[2] = 3'd4; pwm[2] = 8'd9; probe("R6 end busy", 1'b0);
    // R7
    md[0] = 2'd2; ck[0] = 3'd5; nxt[0] = 23'd1639; probe("R7 set 0 long", 1'b1);
    md[0] = 2'd2; ck[0] = 3'd5; nxt[0] = 23'd1638; probe("R7 set 0 short", 1'b0);
    // R8: store a grant, then neutral command keeps it
    md[0] = 2'd2; ck[0] = 3'd3; cyc_stb = 1'b1; step("R8 capture"); cyc_stb = 1'b0;
    ck[0] = 3'd7; probe("R8 neutral holds grant", 1'b1);
    // R9: qualifying without strobe does not enter
    ps_en = 1'b1; repeat (3) step("R9 no strobe");
    #1; cmp("R9 no strobe directed", ps_req, 1'b0);
    // R10: enter then drop
    cyc_stb = 1'b1; step("R10 enter"); cyc_stb = 1'b0;
    md[1] = 2'd1; #1; cmp("R10 drop same cycle", ps_req, 1'b0);
    cmp("R10 wake pulse", wake_req, 1'b1);
    step("R10 drop");
    #1; cmp("R10 wake ends", wake_req, 1'b0);
    idle_all(); ps_en = 1'b0; step("R10 idle");

    // Constrained random, fixed seed
    void'($urandom(32'd1234));
    for (int i = 0; i < 4000; i++) begin
      for (int e = 0; e < NE; e++) begin
        int r = $urandom % 16;
        md[e]  = (r < 7) ? 2'd0 : (r < 13) ? 2'd2 : (r < 15) ? 2'd3 : 2'd1;
        ck[e]  = 3'($urandom % 8);
        rem[e] = 23'(1500 + $urandom % 1300);
        psc[e] = 1'($urandom % 2);
        pwm[e] = ($urandom % 4 == 0) ? 8'($urandom) : 8'd0;
        nxt[e] = 23'(1600 + $urandom % 80);
        ers[e] = 1'($urandom % 2);
      end
      ps_en   = ($urandom % 8) != 0;
      cyc_stb = ($urandom % 4) == 0;
      step("R2 R3 R4 R5 R6 R7 R8 R9 R10 random");
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule